// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every cycle, which hardware thread the instruction fetch stage serves. Each thread reports a fetch status code and an active bit. The selector treats a thread as a candidate only when it is active and its status is one of three codes that permit a new fetch. It then picks one candidate under one of four policies:
- fixed thread zero
- round-robin over an ordered priority list
- least issue-queue occupancy
- least load/store-queue occupancy

The grant is combinational from the current inputs. The grant pair (`grant_valid`, `grant_tid`) acts as a valid/ready offer to the fetch stage, with `advance` as the acceptance. The offer can change whenever the inputs change, and the consumer must not assume it holds while `advance` is low. Internal state changes only on a clock edge where `advance` and `grant_valid` are both high under the round-robin policy. On such an edge the granted thread is moved to the tail of the priority list. With `advance` low, or with no grant offered, the list is left untouched, so holding off the consumer costs no fairness.

When the block is built for a single thread, it grants thread 0 whenever that thread is a candidate, whatever the policy.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is a candidate only when its active bit is 1 and its 3-bit status is 0 (running), 1 (idle) or 6 (cache access done). Status codes 2, 3, 4, 5 and 7 are never granted. Thread i's status sits at bits [3i+2:3i] of `thr_status`.
- R2: When no thread is a candidate, `grant_valid` is 0 under every policy, and `advance` has no effect on the priority list.
- R3: With `policy` = 1 (round-robin), the grant is the first candidate found when scanning the priority list from its head.
- R4: After reset the priority list holds thread IDs in ascending order, so the first round-robin grant is the lowest-numbered candidate.
- R5: On a clock edge where `advance`=1, `grant_valid`=1 and `policy`=1, the granted thread moves to the tail of the list. Entries ahead of it keep their places, and entries behind it each move one place toward the head.
- R6: On an edge with `advance`=0, the priority list is unchanged.
- R7: With `policy` = 2, the grant is the candidate with the smallest issue-queue occupancy, with ties going to the lower thread ID. Thread i's count sits at bits [OCC_W*i +: OCC_W] of `iq_occ`.
- R8: With `policy` = 3, the same rule applies using `lsq_occ`.
- R9: With `policy` = 0, `grant_tid` is 0 and `grant_valid` equals thread 0's candidacy. `cfg_error` is 1 whenever `policy` = 0 and NUM_THREADS > 1, and 0 otherwise.
- R10: Grant outputs follow the inputs in the same cycle, with no register between them.
- R11: `advance` under policies 0, 2 or 3 leaves the priority list unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_status | input | 3*NUM_THREADS | Per-thread fetch status codes |
| thr_active | input | NUM_THREADS | Per-thread active mask |
| iq_occ | input | OCC_W*NUM_THREADS | Per-thread issue-queue occupancy |
| lsq_occ | input | OCC_W*NUM_THREADS | Per-thread load/store-queue occupancy |
| policy | input | 2 | 0 fixed, 1 round-robin, 2 issue-queue count, 3 load/store count |
| advance | input | 1 | Consumer accepts the offered grant this cycle |
| grant_valid | output | 1 | A thread is granted |
| grant_tid | output | TID_W | Granted thread ID |
| cfg_error | output | 1 | Fixed-thread policy chosen with more than one thread |

## Verification
Two things can happen in the same cycle: the offer of a grant, and the list rotation that accepting it triggers. The bench raises `advance` while a grant is offered under round-robin. It then judges the outcome from the grants seen in later cycles, since these reveal whether the pre-rotation winner went to the tail while a skipped, ineligible head stayed in place. The bench also raises `advance` when no grant is offered, and under the count policies. In both cases the next round-robin grant must equal the one seen before.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RUN         = 3'd0,
    ST_IDLE        = 3'd1,
    ST_SQUASH      = 3'd2,
    ST_BLOCKED     = 3'd3,
    ST_WAIT_RETRY  = 3'd4,
    ST_WAIT_RESP   = 3'd5,
    ST_ACCESS_DONE = 3'd6,
    ST_SWITCHED    = 3'd7
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_SINGLE = 2'd0,
    POL_RR     = 2'd1,
    POL_IQ     = 2'd2,
    POL_LSQ    = 2'd3
  } pol_e;

  // R1: the three codes under which a thread may start a fetch
  function automatic logic may_fetch(input logic [STATE_W-1:0] s);
    return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_ACCESS_DONE);
  endfunction

endpackage

// File: rtl/fts_elig.sv
module fts_elig
  import fts_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [STATE_W*NUM_THREADS-1:0] thr_status,
  input  logic [NUM_THREADS-1:0]         thr_active,
  output logic [NUM_THREADS-1:0]         elig
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign elig[t] = thr_active[t] && may_fetch(thr_status[t*STATE_W +: STATE_W]);
  end

endmodule

// File: rtl/fts_occ_min.sv
module fts_occ_min #(
  parameter int NUM_THREADS = 4,
  parameter int OCC_W       = 6,
  parameter int TID_W       = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_THREADS-1:0]       elig,
  input  logic [OCC_W*NUM_THREADS-1:0] occ,
  output logic                         found,
  output logic [TID_W-1:0]             tid
);

  logic [OCC_W-1:0] best;

  // strict less-than keeps the lower ID on a tie (R7, R8)
  always_comb begin
    found = 1'b0;
    tid   = '0;
    best  = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (elig[t] && (!found || occ[t*OCC_W +: OCC_W] < best)) begin
        found = 1'b1;
        tid   = TID_W'(t);
        best  = occ[t*OCC_W +: OCC_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      a_r7_found_any : assert (found == (|elig))
        else $error("occupancy selector found flag disagrees with candidates");
      for (int t = 0; t < NUM_THREADS; t++) begin
        a_r8_no_smaller : assert (!(found && elig[t]) ||
                                  occ[int'(tid)*OCC_W +: OCC_W] <= occ[t*OCC_W +: OCC_W])
          else $error("a candidate has smaller occupancy than the winner");
      end
    end
  end

endmodule

// File: rtl/fts_rr_list.sv
module fts_rr_list #(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] elig,
  input  logic                   rotate,
  output logic                   hit,
  output logic [TID_W-1:0]       head_tid
);

  localparam int LIST_W = NUM_THREADS * TID_W;

  logic [LIST_W-1:0] order_q, order_d;
  logic [TID_W-1:0]  pos;

  // scan from the head for the first candidate (R3)
  always_comb begin
    hit      = 1'b0;
    pos      = '0;
    head_tid = '0;
    for (int p = 0; p < NUM_THREADS; p++) begin
      if (!hit && elig[order_q[p*TID_W +: TID_W]]) begin
        hit      = 1'b1;
        pos      = TID_W'(p);
        head_tid = order_q[p*TID_W +: TID_W];
      end
    end
  end

  // winner leaves its slot, later entries close the gap, winner goes last (R5)
  always_comb begin
    for (int p = 0; p < NUM_THREADS - 1; p++) begin
      if (p < int'(pos)) order_d[p*TID_W +: TID_W] = order_q[p*TID_W +: TID_W];
      else               order_d[p*TID_W +: TID_W] = order_q[(p+1)*TID_W +: TID_W];
    end
    order_d[(NUM_THREADS-1)*TID_W +: TID_W] = head_tid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_THREADS; p++) order_q[p*TID_W +: TID_W] <= TID_W'(p); // R4
    end else if (rotate && hit) begin
      order_q <= order_d;
    end
  end

  // list must always be a permutation of the thread IDs
  logic [NUM_THREADS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int p = 0; p < NUM_THREADS; p++) seen[order_q[p*TID_W +: TID_W]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      a_r5_permutation : assert (&seen)
        else $error("priority list lost a thread ID");
    end
  end

  a_r5_tail : assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && hit) |=> order_q[(NUM_THREADS-1)*TID_W +: TID_W] == $past(head_tid))
    else $error("granted thread not moved to the tail");

  a_r6_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !rotate |=> $stable(order_q))
    else $error("priority list changed without rotation");

  a_r3_hit_eligible : assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> elig[head_tid])
    else $error("round-robin picked a non-candidate");

endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fts_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int OCC_W       = 6,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [STATE_W*NUM_THREADS-1:0] thr_status,
  input  logic [NUM_THREADS-1:0]         thr_active,
  input  logic [OCC_W*NUM_THREADS-1:0]   iq_occ,
  input  logic [OCC_W*NUM_THREADS-1:0]   lsq_occ,
  input  logic [1:0]                     policy,
  input  logic                           advance,
  output logic                           grant_valid,
  output logic [TID_W-1:0]               grant_tid,
  output logic                           cfg_error
);

  logic [NUM_THREADS-1:0] elig;
  pol_e                   pol;

  assign pol = pol_e'(policy);

  fts_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .thr_status (thr_status),
    .thr_active (thr_active),
    .elig       (elig)
  );

  if (NUM_THREADS == 1) begin : g_one
    // single thread build: grant it whenever it may fetch
    assign grant_valid = elig[0];
    assign grant_tid   = '0;
    assign cfg_error   = 1'b0;
  end else begin : g_multi
    logic             rr_hit, rotate;
    logic [TID_W-1:0] rr_tid;
    logic [1:0]       cnt_found;
    logic [TID_W-1:0] cnt_tid [2];

    assign rotate = advance && grant_valid && (pol == POL_RR);

    fts_rr_list #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_rr (
      .clk      (clk),
      .rst_n    (rst_n),
      .elig     (elig),
      .rotate   (rotate),
      .hit      (rr_hit),
      .head_tid (rr_tid)
    );

    for (genvar q = 0; q < 2; q++) begin : g_cnt
      fts_occ_min #(.NUM_THREADS(NUM_THREADS), .OCC_W(OCC_W), .TID_W(TID_W)) u_min (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .occ   ((q == 0) ? iq_occ : lsq_occ),
        .found (cnt_found[q]),
        .tid   (cnt_tid[q])
      );
    end

    always_comb begin
      unique case (pol)
        POL_SINGLE: begin grant_valid = elig[0];      grant_tid = '0;         end
        POL_RR:     begin grant_valid = rr_hit;       grant_tid = rr_tid;     end
        POL_IQ:     begin grant_valid = cnt_found[0]; grant_tid = cnt_tid[0]; end
        default:    begin grant_valid = cnt_found[1]; grant_tid = cnt_tid[1]; end
      endcase
    end

    assign cfg_error = (pol == POL_SINGLE);
  end

  a_r1_grant_eligible : assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (thr_active[grant_tid] &&
                     may_fetch(thr_status[int'(grant_tid)*STATE_W +: STATE_W])))
    else $error("grant given to a thread that may not fetch");

  a_r2_none_no_grant : assert property (@(posedge clk) disable iff (!rst_n)
    !(|elig) |-> !grant_valid)
    else $error("grant offered with no candidate");

  a_r9_single_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'd0 && grant_valid) |-> grant_tid == '0)
    else $error("fixed policy granted a nonzero thread");

endmodule

// File: tb/fetch_thread_sel_test.sv
module fetch_thread_sel_test;

  localparam int NT = 4;
  localparam int OW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   thr_status = '0;
  logic [3:0]    thr_active = '0;
  logic [23:0]   iq_occ = '0;
  logic [23:0]   lsq_occ = '0;
  logic [1:0]    policy = 2'd1;
  logic          advance = 1'b0;
  logic          grant_valid;
  logic [1:0]    grant_tid;
  logic          cfg_error;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fetch_thread_sel #(.NUM_THREADS(NT), .OCC_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .thr_status(thr_status), .thr_active(thr_active),
    .iq_occ(iq_occ), .lsq_occ(lsq_occ), .policy(policy), .advance(advance),
    .grant_valid(grant_valid), .grant_tid(grant_tid), .cfg_error(cfg_error)
  );

  typedef struct packed {
    logic [11:0] st;   // {t3,t2,t1,t0} 3-bit status codes
    logic [3:0]  act;
    logic [23:0] iq;   // {t3,t2,t1,t0}
    logic [23:0] lsq;
    logic [1:0]  pol;
    logic        ev;
    logic [1:0]  et;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R7 smallest issue-queue count wins
    '{ {3'd0,3'd0,3'd0,3'd0}, 4'hF, {6'd5,6'd3,6'd7,6'd4}, {6'd0,6'd0,6'd0,6'd0}, 2'd2, 1'b1, 2'd2, 8'd7 },
    // R7 tie goes to lower ID
    '{ {3'd0,3'd0,3'd0,3'd0}, 4'hF, {6'd5,6'd3,6'd3,6'd4}, {6'd0,6'd0,6'd0,6'd0}, 2'd2, 1'b1, 2'd1, 8'd7 },
    // R1 blocked thread skipped despite smallest count
    '{ {3'd0,3'd0,3'd3,3'd0}, 4'hF, {6'd5,6'd3,6'd1,6'd4}, {6'd0,6'd0,6'd0,6'd0}, 2'd2, 1'b1, 2'd2, 8'd1 },
    // R8 load/store count
    '{ {3'd0,3'd0,3'd0,3'd0}, 4'hF, {6'd0,6'd0,6'd0,6'd0}, {6'd2,6'd9,6'd9,6'd9}, 2'd3, 1'b1, 2'd3, 8'd8 },
    // R8 inactive thread skipped, three-way tie
    '{ {3'd0,3'd0,3'd0,3'd0}, 4'h7, {6'd0,6'd0,6'd0,6'd0}, {6'd2,6'd9,6'd9,6'd9}, 2'd3, 1'b1, 2'd0, 8'd8 },
    // R2 all statuses ineligible
    '{ {3'd2,3'd3,3'd4,3'd5}, 4'hF, {6'd1,6'd1,6'd1,6'd1}, {6'd0,6'd0,6'd0,6'd0}, 2'd2, 1'b0, 2'd0, 8'd2 },
    // R1 codes 7 and 5 excluded, 6 and 1 allowed
    '{ {3'd7,3'd6,3'd1,3'd5}, 4'hF, {6'd0,6'd8,6'd6,6'd0}, {6'd0,6'd0,6'd0,6'd0}, 2'd2, 1'b1, 2'd1, 8'd1 },
    // R9 fixed policy, thread 0 running
    '{ {3'd3,3'd3,3'd0,3'd0}, 4'hF, {6'd0,6'd0,6'd0,6'd0}, {6'd0,6'd0,6'd0,6'd0}, 2'd0, 1'b1, 2'd0, 8'd9 },
    // R9 fixed policy, thread 0 blocked
    '{ {3'd0,3'd0,3'd0,3'd3}, 4'hF, {6'd0,6'd0,6'd0,6'd0}, {6'd0,6'd0,6'd0,6'd0}, 2'd0, 1'b0, 2'd0, 8'd9 },
    // R2 no thread active
    '{ {3'd0,3'd0,3'd0,3'd0}, 4'h0, {6'd0,6'd0,6'd0,6'd0}, {6'd0,6'd0,6'd0,6'd0}, 2'd3, 1'b0, 2'd0, 8'd2 }
  };

  task automatic check_grant(input string tag, input logic ev, input logic [1:0] et);
    checks++;
    if (grant_valid !== ev || (ev && grant_tid !== et)) begin
      errors++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               tag, grant_valid, grant_tid, ev, et);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b, expected %0b", tag, got, exp);
    end
  endtask

  // raise advance for exactly one rising edge, then settle
  task automatic pulse_advance();
    @(negedge clk); advance = 1'b1;
    @(negedge clk); advance = 1'b0;
    #1;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  localparam logic [11:0] ALL_RUN   = 12'h000;
  localparam logic [11:0] T3_BLOCK  = {3'd3, 3'd0, 3'd0, 3'd0};
  localparam logic [11:0] ALL_BLOCK = {3'd3, 3'd3, 3'd3, 3'd3};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    thr_status = ALL_RUN; thr_active = 4'hF; policy = 2'd1;
    #1;
    check_grant("R4 reset list ascending, first grant thread 0", 1'b1, 2'd0);
    check_bit("R9 cfg_error low under round-robin", cfg_error, 1'b0);

    // table: combinational selection, advance held low (R10)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      thr_status = VECS[v].st; thr_active = VECS[v].act;
      iq_occ = VECS[v].iq; lsq_occ = VECS[v].lsq; policy = VECS[v].pol;
      #1;
      check_grant($sformatf("R%0d R10 table vector %0d", VECS[v].req, v), VECS[v].ev, VECS[v].et);
      check_bit($sformatf("R9 cfg_error vector %0d", v), cfg_error, VECS[v].pol == 2'd0);
    end

    // list still in reset order after table (advance was low): R6
    @(negedge clk);
    thr_status = ALL_RUN; thr_active = 4'hF; policy = 2'd1; #1;
    check_grant("R6 list untouched by table walk", 1'b1, 2'd0);

    pulse_advance();   // list 1,2,3,0
    check_grant("R5 thread 0 moved to tail", 1'b1, 2'd1);
    pulse_advance();   // list 2,3,0,1
    check_grant("R5 second rotation", 1'b1, 2'd2);

    @(negedge clk); thr_status = T3_BLOCK; #1;
    check_grant("R3 head candidate still first", 1'b1, 2'd2);
    pulse_advance();   // list 3,0,1,2
    check_grant("R3 blocked head skipped", 1'b1, 2'd0);
    pulse_advance();   // list 3,1,2,0 : skipped head stays
    check_grant("R5 entries behind winner move up", 1'b1, 2'd1);

    @(negedge clk); thr_status = ALL_RUN; #1;
    check_grant("R5 skipped thread kept its head place", 1'b1, 2'd3);
    idle_cycles(4);
    check_grant("R6 advance low holds list", 1'b1, 2'd3);

    // advance under count policy must not rotate (R11)
    @(negedge clk); policy = 2'd2; iq_occ = {6'd9, 6'd9, 6'd9, 6'd1}; #1;
    check_grant("R7 count grant while advance pending", 1'b1, 2'd0);
    pulse_advance();
    @(negedge clk); policy = 2'd1; #1;
    check_grant("R11 count-policy advance left list alone", 1'b1, 2'd3);

    // advance with no candidate (R2)
    @(negedge clk); thr_status = ALL_BLOCK; #1;
    check_grant("R2 no candidate under round-robin", 1'b0, 2'd0);
    pulse_advance();
    @(negedge clk); thr_status = ALL_RUN; #1;
    check_grant("R2 advance without grant left list alone", 1'b1, 2'd3);

    // reset restores ascending order (R4)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    check_grant("R4 reset restores ascending list", 1'b1, 2'd0);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule